// File: doc/BRIEF.md
# Security Fault Status Capture

This block keeps the record of security faults that the core-side checking logic reports. Each fault cause arrives as a one-cycle event pulse. The block turns every pulse into a sticky flag in an 8-bit status register. When a fault comes with a qualified address, the block also stores that address in a 32-bit fault address register and sets an address-valid flag. The logic that detects the faults, such as exception-return checks and branch analysis, lies outside this block.

Software reads both registers through a simple register bus and clears status flags by writing ones to them. An attribution violation raised while lazy floating-point state preservation is in progress is steered to its own flag. A clear request from unrelated fault types can drop the address-valid flag. While any cause flag is set, a single fault interrupt line stays high.

Top module: `sec_fault_log`

## Requirements
- R1: After reset, the status register (offset 0x14) and the fault address register (offset 0x18) both read 0, and `faultIrq` is low.
- R2: A pulse on `faultEvt[i]` sets one status bit on the next clock edge. Index 0 sets bit 0 (invalid entry point). Index 1 sets bit 1 (invalid integrity signature). Index 2 sets bit 2 (invalid exception return). Index 3 sets bit 3 (attribution violation). Index 4 sets bit 4 (invalid transition). Index 5 sets bit 7 (lazy state error). Each set bit stays set until it is cleared.
- R3: If `faultEvt[3]` arrives while `lazyCtx` is high, the block sets status bit 5 (lazy-preservation violation) and leaves bit 3 unchanged.
- R4: A bus write to offset 0x14 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits as they were. Status bits [31:8] always read 0. Offsets other than 0x14 and 0x18 read 0. Writes to 0x18 have no effect.
- R5: The block captures `faultAddr` into the address register and sets status bit 6 (address valid) when all three of these hold in the same cycle: at least one `faultEvt` bit pulses, `faultAddrVld` is high, and bit 6 is currently clear.
- R6: While bit 6 is set, a new address-qualified fault does not change the address register.
- R7: `otherFaultClr` clears status bit 6 only. After that, the next address-qualified fault captures again.
- R8: If a fault sets a bit in the same cycle that a software clear or `otherFaultClr` clears it, the bit ends up set.
- R9: `faultIrq` is high exactly when any of status bits [5:0] or bit 7 is set. Bit 6 alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultEvt | input | 6 | One-cycle fault cause pulses (mapping in R2) |
| lazyCtx | input | 1 | Lazy floating-point preservation is in progress |
| faultAddr | input | 32 | Address of the faulting access |
| faultAddrVld | input | 1 | `faultAddr` is meaningful this cycle |
| otherFaultClr | input | 1 | Clear request for the address-valid flag from other fault types |
| busAddr | input | 8 | Register byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| faultIrq | output | 1 | Fault interrupt |

## Verification
The bench aims at four corner cases.

- **Attribution fault in lazy context.** A design that ignored the context would set bit 3 and leave bit 5 clear.
- **Second address-qualified fault while the valid flag is set.** A design that always loaded the address would overwrite the first fault's address.
- **Set and clear in the same cycle.** This covers both a software clear and `otherFaultClr`. A design where the clear wins would lose the new fault.
- **Partial write-one-to-clear patterns and zero writes.** A design that wrote the data straight into the register would wipe or set flags that were not targeted.

Random traffic then mixes all of these, and after every cycle the bench compares both registers and the interrupt against its own model.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam int STAT_W  = 8;
  localparam int EVT_W   = 6;

  localparam int BIT_ENTRY = 0;
  localparam int BIT_SIG   = 1;
  localparam int BIT_RET   = 2;
  localparam int BIT_ATTR  = 3;
  localparam int BIT_TRANS = 4;
  localparam int BIT_LAZYV = 5;
  localparam int BIT_AVLD  = 6;
  localparam int BIT_LERR  = 7;

  localparam logic [STAT_W-1:0] IRQ_MASK = 8'hBF;

  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
    logic              capture;
  } sfl_strobe_t;

endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter logic [BUS_AW-1:0] STAT_OFS = 'h14
) (
  input  logic [EVT_W-1:0]  faultEvt,
  input  logic              lazyCtx,
  input  logic              faultAddrVld,
  input  logic              otherFaultClr,
  input  logic              busWrEn,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [STAT_W-1:0] wrByte,
  input  logic              addrValidQ,
  output sfl_strobe_t       strb
);

  logic anyEvt;
  logic statWr;

  assign anyEvt = |faultEvt;
  assign statWr = busWrEn && (busAddr == STAT_OFS);

  // cause steering: attribution fault during lazy preservation takes its own flag
  always_comb begin
    strb.setMask = '0;
    strb.setMask[BIT_ENTRY] = faultEvt[0];
    strb.setMask[BIT_SIG]   = faultEvt[1];
    strb.setMask[BIT_RET]   = faultEvt[2];
    strb.setMask[BIT_ATTR]  = faultEvt[3] && !lazyCtx;
    strb.setMask[BIT_LAZYV] = faultEvt[3] && lazyCtx;
    strb.setMask[BIT_TRANS] = faultEvt[4];
    strb.setMask[BIT_LERR]  = faultEvt[5];
    strb.setMask[BIT_AVLD]  = strb.capture;
  end

  // first qualified address wins; later ones are dropped while valid is held
  assign strb.capture = anyEvt && faultAddrVld && !addrValidQ;

  always_comb begin
    strb.clrMask = statWr ? wrByte : '0;
    if (otherFaultClr) strb.clrMask[BIT_AVLD] = 1'b1;
  end

endmodule

// File: rtl/sfl_regs.sv
module sfl_regs
  import sfl_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int DATA_W = 32,
  parameter int FAR_W  = 32,
  parameter logic [BUS_AW-1:0] STAT_OFS = 'h14,
  parameter logic [BUS_AW-1:0] FAR_OFS  = 'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfl_strobe_t       strb,
  input  logic [FAR_W-1:0]  faultAddr,
  input  logic [BUS_AW-1:0] busAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] statQ,
  output logic [FAR_W-1:0]  farQ,
  output logic              irq
);

  logic [STAT_W-1:0] statD;

  // set has priority over clear, bit by bit
  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_bit
      assign statD[gi] = strb.setMask[gi] | (statQ[gi] & ~strb.clrMask[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      farQ  <= '0;
    end else begin
      statQ <= statD;
      if (strb.capture) farQ <= faultAddr;
    end
  end

  always_comb begin
    rdData = '0;
    if (busAddr == STAT_OFS)     rdData[STAT_W-1:0] = statQ;
    else if (busAddr == FAR_OFS) rdData[FAR_W-1:0]  = farQ;
  end

  assign irq = |(statQ & IRQ_MASK);

endmodule

// File: rtl/sec_fault_log.sv
module sec_fault_log
  import sfl_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int DATA_W = 32,
  parameter int FAR_W  = 32,
  parameter logic [BUS_AW-1:0] STAT_OFS = 'h14,
  parameter logic [BUS_AW-1:0] FAR_OFS  = 'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        faultEvt,
  input  logic              lazyCtx,
  input  logic [31:0]       faultAddr,
  input  logic              faultAddrVld,
  input  logic              otherFaultClr,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              faultIrq
);

  sfl_strobe_t       strb;
  logic [STAT_W-1:0] statQ;
  logic [FAR_W-1:0]  farQ;

  sfl_ctrl #(.BUS_AW(BUS_AW), .STAT_OFS(STAT_OFS)) u_ctrl (
    .faultEvt     (faultEvt),
    .lazyCtx      (lazyCtx),
    .faultAddrVld (faultAddrVld),
    .otherFaultClr(otherFaultClr),
    .busWrEn      (busWrEn),
    .busAddr      (busAddr),
    .wrByte       (busWrData[STAT_W-1:0]),
    .addrValidQ   (statQ[BIT_AVLD]),
    .strb         (strb)
  );

  sfl_regs #(
    .BUS_AW(BUS_AW), .DATA_W(DATA_W), .FAR_W(FAR_W),
    .STAT_OFS(STAT_OFS), .FAR_OFS(FAR_OFS)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .faultAddr(faultAddr),
    .busAddr  (busAddr),
    .rdData   (busRdData),
    .statQ    (statQ),
    .farQ     (farQ),
    .irq      (faultIrq)
  );

endmodule

// File: rtl/sfl_checker.sv
module sfl_checker (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  faultEvt,
  input logic        lazyCtx,
  input logic        otherFaultClr,
  input logic [7:0]  busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic        faultIrq,
  input logic [7:0]  statQ,
  input logic [31:0] farQ
);

  logic [7:0] swMask;
  assign swMask = (busWrEn && busAddr == 8'h14) ? busWrData[7:0] : 8'h00;

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(statQ) & ~$past(swMask) & ~statQ) & 8'hBF) == 8'h00)); // R2

  AST_LAZY_STEER: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvt[3] && lazyCtx && !statQ[3] && faultEvt[5:4] == 2'b00) |=> (statQ[5] && !statQ[3])); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h14) |-> (busRdData[31:8] == 24'h0)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    statQ[6] |=> $stable(farQ)); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[6] && !swMask[6] && !otherFaultClr) |=> statQ[6]); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvt[0] && swMask[0]) |=> statQ[0]); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultIrq) |-> $past(|faultEvt)); // R9

endmodule

bind sec_fault_log sfl_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .faultEvt     (faultEvt),
  .lazyCtx      (lazyCtx),
  .otherFaultClr(otherFaultClr),
  .busAddr      (busAddr),
  .busWrEn      (busWrEn),
  .busWrData    (busWrData),
  .busRdData    (busRdData),
  .faultIrq     (faultIrq),
  .statQ        (statQ),
  .farQ         (farQ)
);

// File: tb/sec_fault_log_tb.sv
module sec_fault_log_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  faultEvt;
  logic        lazyCtx;
  logic [31:0] faultAddr;
  logic        faultAddrVld;
  logic        otherFaultClr;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        faultIrq;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  expStat;
  logic [31:0] expFar;

  always #10 clk = ~clk;

  sec_fault_log u_dut (
    .clk(clk), .rstN(rstN), .faultEvt(faultEvt), .lazyCtx(lazyCtx),
    .faultAddr(faultAddr), .faultAddrVld(faultAddrVld),
    .otherFaultClr(otherFaultClr), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .faultIrq(faultIrq)
  );

  function automatic logic [7:0] setOf(logic [5:0] e, logic lz, logic av, logic vq);
    logic [7:0] s = 8'h00;
    s[0] = e[0]; s[1] = e[1]; s[2] = e[2];
    s[3] = e[3] && !lz; s[5] = e[3] && lz;
    s[4] = e[4]; s[7] = e[5];
    s[6] = (|e) && av && !vq;
    return s;
  endfunction

  function automatic logic [7:0] clrOf(logic wr, logic [7:0] a, logic [7:0] d, logic oc);
    logic [7:0] c = (wr && a == 8'h14) ? d : 8'h00;
    if (oc) c[6] = 1'b1;
    return c;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    faultEvt = '0; lazyCtx = 0; faultAddr = '0; faultAddrVld = 0;
    otherFaultClr = 0; busWrEn = 0; busWrData = '0; busAddr = 8'h14;
  endtask

  task automatic readAll(string tag);
    busAddr = 8'h14; #1;
    check(tag, "status", busRdData, {24'h0, expStat});
    busAddr = 8'h18; #1;
    check(tag, "address", busRdData, expFar);
    check(tag, "irq", {31'h0, faultIrq}, {31'h0, |(expStat & 8'hBF)});
  endtask

  task automatic step(string tag, logic [5:0] e, logic lz, logic [31:0] ad, logic av,
                      logic oc, logic wr, logic [7:0] wa, logic [31:0] wd);
    logic [7:0] s, c;
    @(negedge clk);
    faultEvt = e; lazyCtx = lz; faultAddr = ad; faultAddrVld = av;
    otherFaultClr = oc; busWrEn = wr; busAddr = wa; busWrData = wd;
    @(posedge clk);
    s = setOf(e, lz, av, expStat[6]);
    c = clrOf(wr, wa, wd[7:0], oc);
    if (s[6]) expFar = ad;
    expStat = s | (expStat & ~c);
    #2; idle();
    readAll(tag);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    idle(); rstN = 0; expStat = 0; expFar = 0;
    repeat (3) @(posedge clk);
    #2; readAll("R1");
    @(negedge clk); rstN = 1;

    // R2 each cause sets its flag
    step("R2", 6'b000001, 0, 0, 0, 0, 0, 8'h14, 0);
    step("R2", 6'b000010, 0, 0, 0, 0, 0, 8'h14, 0);
    step("R2", 6'b000100, 0, 0, 0, 0, 0, 8'h14, 0);
    step("R2", 6'b010000, 0, 0, 0, 0, 0, 8'h14, 0);
    step("R2", 6'b100000, 0, 0, 0, 0, 0, 8'h14, 0);
    step("R2", 6'b001000, 0, 0, 0, 0, 0, 8'h14, 0);
    // R4 write zero leaves flags, partial clear
    step("R4", 0, 0, 0, 0, 0, 1, 8'h14, 32'hFFFF_FF00);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h14, 32'h0000_0005);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h14, 32'hFFFF_FFFF);
    // R3 lazy steering
    step("R3", 6'b001000, 1, 0, 0, 0, 0, 8'h14, 0);
    // R5 capture, R6 no overwrite
    step("R5", 6'b000001, 0, 32'hDEAD_BEEF, 1, 0, 0, 8'h14, 0);
    step("R6", 6'b000010, 0, 32'h1234_5678, 1, 0, 0, 8'h14, 0);
    // R4 write to address offset ignored, other offsets read 0
    step("R4", 0, 0, 0, 0, 0, 1, 8'h18, 32'h5555_5555);
    busAddr = 8'h1C; #1; check("R4", "unmapped read", busRdData, 32'h0);
    busAddr = 8'h10; #1; check("R4", "unmapped read", busRdData, 32'h0);
    // R7 other fault clears valid only, then recapture
    step("R7", 0, 0, 0, 0, 1, 0, 8'h14, 0);
    step("R7", 6'b000100, 0, 32'hCAFE_0010, 1, 0, 0, 8'h14, 0);
    // R8 set wins over clear
    step("R8", 6'b000001, 0, 0, 0, 0, 1, 8'h14, 32'h0000_00FF);
    step("R8", 6'b000010, 0, 32'hA5A5_0000, 1, 1, 0, 8'h14, 0);
    // R9 valid alone does not interrupt
    step("R9", 0, 0, 0, 0, 0, 1, 8'h14, 32'h0000_00BF);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] e;
      logic [7:0] wa;
      e = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      wa = ($urandom % 2) ? 8'h14 : (($urandom % 2) ? 8'h18 : 8'h0C);
      step("R2", e, 1'($urandom), $urandom, 1'($urandom), ($urandom % 8 == 0),
           ($urandom % 3 == 0), wa, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule